// File: doc/BRIEF.md
# Multicycle Issue Interlock

This block sits at the issue point of a single-issue, in-order pipeline whose execute stage has four functional units with different depths. The units are an integer ALU, a pipelined multiplier, a pipelined adder and a non-pipelined divider. Each cycle the decoder presents at most one instruction. It is described by a unit class, a destination register, two source registers and an enable bit for each register field. The interlock either lets the instruction issue in that cycle or holds it with a stall, and it reports which kind of hazard caused the hold.

Three kinds of state are kept. The first is a per-register countdown of the cycles left until a pending result can be forwarded, which also gives the cycle in which that result is written. The second is a shift vector of reserved write-back cycles, which guards the single write port shared by all units. The third is a small state machine for divider occupancy, with two states. `DIV_IDLE` moves to `DIV_BUSY` when a divide issues. `DIV_BUSY` counts down and returns to `DIV_IDLE` once its count reaches zero. Only instructions that actually issue change any of this state. Decode, forwarding selection and the datapath are outside the block.

An instruction on a unit with E execute stages that issues in cycle t writes back in cycle t+E. A dependent instruction may issue from cycle t+E onwards, which is E-1 stall cycles after back-to-back issue. The stage counts are INT 1, MUL 7, ADD 4 and DIV 25.

Top module: `issue_interlock`

## Requirements
- R1: After reset no register is pending, the divider is free and no write-back cycle is reserved, so any valid instruction issues at once.
- R2: `issue` is high exactly when `in_valid` is high and no hazard flag is set. `stall` is high exactly when `in_valid` is high and at least one hazard flag is set. With `in_valid` low, `issue`, `stall` and all hazard flags are low.
- R3: RAW. If a producer with an enabled destination issues in cycle t on a unit with E stages, an instruction reading that register through an enabled source raises `haz_raw` in cycles t+1 to t+E-1 and is free of RAW from t+E. This gives 0 stall cycles for INT, 6 for MUL and 3 for ADD.
- R4: The divider has 25 stages, so a consumer of its result sees `haz_raw` for 24 cycles. A second divide raises `haz_struct` until 25 cycles after the previous divide issued.
- R5: Every issued instruction reserves the write-back cycle t+E. An instruction whose write-back cycle is already reserved raises `haz_struct`. For example, an ADD issued 3 cycles after a MUL is held.
- R6: WAW. `haz_waw` is raised when the enabled destination has a pending write that lands in the same cycle as the new write, or later. A slower write to the same register issued after a faster one is allowed.
- R7: A source or destination field whose enable bit is low takes no part in hazard checks. A destination with its enable low creates no pending state.
- R8: A stalled instruction reserves nothing. It leaves no pending register and no write-back reservation behind.
- R9: Unit class encoding: 0 = INT, 1 = MUL, 2 = ADD, 3 = DIV.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_unit | input | 2 | Unit class (R9 encoding) |
| in_dst | input | 5 | Destination register |
| in_dst_en | input | 1 | Destination field is used |
| in_srca | input | 5 | First source register |
| in_srca_en | input | 1 | First source field is used |
| in_srcb | input | 5 | Second source register |
| in_srcb_en | input | 1 | Second source field is used |
| issue | output | 1 | Instruction issues this cycle |
| stall | output | 1 | Instruction is held this cycle |
| haz_struct | output | 1 | Divider busy or write-back cycle taken |
| haz_raw | output | 1 | A source is not yet forwardable |
| haz_waw | output | 1 | Destination write would not land after a pending one |

## Verification
The assertions check on every cycle that `issue` and `stall` never rise together and that both stay low without `in_valid`. They also check that no divide issues sooner than 25 cycles after the previous one, that an integer result is usable in the very next cycle, that a dependent of a multiply is always held the cycle after it, and that a faster write to a register a multiply has just claimed never issues. Only the bench scenarios show the exact length of each stall window for every unit, write-back port collisions, disabled register fields being ignored, and that a held instruction leaves no reservation behind.

// File: rtl/il_pkg.sv
package il_pkg;

    // Unit class as presented by the decoder (R9)
    typedef enum logic [1:0] {
        UNIT_INT = 2'd0,
        UNIT_MUL = 2'd1,
        UNIT_ADD = 2'd2,
        UNIT_DIV = 2'd3
    } unit_e;

    // Divider occupancy states
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_BUSY = 1'b1
    } div_state_e;

endpackage

// File: rtl/il_reg_track.sv
// Per-register countdown of cycles until a pending result is forwardable.
module il_reg_track #(
    parameter int NREG = 32,
    parameter int CW   = 5,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    input  logic [CW-1:0] set_val,
    input  logic [IW-1:0] rd_a,
    input  logic [IW-1:0] rd_b,
    input  logic [IW-1:0] rd_d,
    output logic [CW-1:0] cnt_a,
    output logic [CW-1:0] cnt_b,
    output logic [CW-1:0] cnt_d
);

    logic [CW-1:0] cnt_arr [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [CW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q <= '0;
            end else if (set_en && set_idx == IW'(g)) begin
                cnt_q <= set_val;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
        assign cnt_arr[g] = cnt_q;
    end

    assign cnt_a = cnt_arr[rd_a];
    assign cnt_b = cnt_arr[rd_b];
    assign cnt_d = cnt_arr[rd_d];

endmodule

// File: rtl/il_wb_ring.sv
// Shift vector of reserved write-back cycles; bit k set = a write lands k cycles from now.
module il_wb_ring #(
    parameter int DEPTH = 26,
    localparam int SW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rsv_en,
    input  logic [SW-1:0] rsv_at,
    input  logic [SW-1:0] probe_at,
    output logic          taken
);

    logic [DEPTH-1:0] slot;

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        logic bit_q;
        logic shift_in;
        if (k < DEPTH - 1) begin : g_mid
            assign shift_in = slot[k+1];
        end else begin : g_top
            assign shift_in = 1'b0;
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= shift_in | (rsv_en && rsv_at == SW'(k + 1));
            end
        end
        assign slot[k] = bit_q;
    end

    assign taken = slot[probe_at];

endmodule

// File: rtl/il_div_fsm.sv
// Occupancy tracker for the non-pipelined divider.
module il_div_fsm
    import il_pkg::*;
#(
    parameter int II = 25,
    parameter int CW = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);

    div_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DIV_IDLE: begin
                if (start) begin
                    state_d = DIV_BUSY;
                    cnt_d   = CW'(II - 2);
                end
            end
            DIV_BUSY: begin
                if (cnt_q == '0) begin
                    state_d = DIV_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
        endcase
    end

    always_comb begin
        busy = (state_q == DIV_BUSY);
    end

endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
    import il_pkg::*;
#(
    parameter int NREG       = 32,
    parameter int INT_STAGES = 1,
    parameter int MUL_STAGES = 7,
    parameter int ADD_STAGES = 4,
    parameter int DIV_STAGES = 25,
    parameter int DIV_II     = 25,
    localparam int IW        = $clog2(NREG),
    localparam int DEPTH     = DIV_STAGES + 1,
    localparam int CW        = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [1:0]    in_unit,
    input  logic [IW-1:0] in_dst,
    input  logic          in_dst_en,
    input  logic [IW-1:0] in_srca,
    input  logic          in_srca_en,
    input  logic [IW-1:0] in_srcb,
    input  logic          in_srcb_en,
    output logic          issue,
    output logic          stall,
    output logic          haz_struct,
    output logic          haz_raw,
    output logic          haz_waw
);

    unit_e         unit;
    logic [CW-1:0] stages;
    logic [CW-1:0] cnt_a, cnt_b, cnt_d;
    logic          slot_taken, div_busy, is_div;
    logic          s_hit, r_hit, w_hit;

    assign unit   = unit_e'(in_unit);
    assign is_div = (unit == UNIT_DIV);

    always_comb begin
        unique case (unit)
            UNIT_INT: stages = CW'(INT_STAGES);
            UNIT_MUL: stages = CW'(MUL_STAGES);
            UNIT_ADD: stages = CW'(ADD_STAGES);
            UNIT_DIV: stages = CW'(DIV_STAGES);
        endcase
    end

    il_reg_track #(.NREG(NREG), .CW(CW)) track_i (
        .clk     (clk),
        .rst     (rst),
        .set_en  (issue && in_dst_en),
        .set_idx (in_dst),
        .set_val (stages - 1'b1),
        .rd_a    (in_srca),
        .rd_b    (in_srcb),
        .rd_d    (in_dst),
        .cnt_a   (cnt_a),
        .cnt_b   (cnt_b),
        .cnt_d   (cnt_d)
    );

    il_wb_ring #(.DEPTH(DEPTH)) ring_i (
        .clk      (clk),
        .rst      (rst),
        .rsv_en   (issue),
        .rsv_at   (stages),
        .probe_at (stages),
        .taken    (slot_taken)
    );

    il_div_fsm #(.II(DIV_II), .CW(CW)) div_i (
        .clk   (clk),
        .rst   (rst),
        .start (issue && is_div),
        .busy  (div_busy)
    );

    always_comb begin
        r_hit = (in_srca_en && cnt_a != '0) || (in_srcb_en && cnt_b != '0);
        w_hit = in_dst_en && cnt_d != '0 && stages <= cnt_d;
        s_hit = slot_taken || (is_div && div_busy);
    end

    always_comb begin
        haz_raw    = in_valid && r_hit;
        haz_waw    = in_valid && w_hit;
        haz_struct = in_valid && s_hit;
        stall      = in_valid && (r_hit || w_hit || s_hit);
        issue      = in_valid && !(r_hit || w_hit || s_hit);
    end

endmodule

// File: rtl/issue_interlock_chk.sv
module issue_interlock_chk #(
    parameter int IW     = 5,
    parameter int DIV_II = 25,
    localparam int GW    = $clog2(DIV_II + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [1:0]    in_unit,
    input logic [IW-1:0] in_dst,
    input logic          in_dst_en,
    input logic [IW-1:0] in_srca,
    input logic          in_srca_en,
    input logic          in_srcb_en,
    input logic          issue,
    input logic          stall,
    input logic          haz_struct,
    input logic          haz_raw,
    input logic          haz_waw
);

    logic [GW-1:0] since_div;
    logic          rst_seen = 1'b1;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst) begin
            since_div <= GW'(DIV_II);
        end else if (issue && in_unit == 2'd3) begin
            since_div <= GW'(1);
        end else if (since_div < GW'(DIV_II)) begin
            since_div <= since_div + 1'b1;
        end
    end

    p_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(issue && stall));

    p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> (!issue && !stall && !haz_raw && !haz_waw && !haz_struct));

    p_clean_start_r1: assert property (@(posedge clk) disable iff (rst)
        rst_seen |-> !(haz_raw || haz_waw || haz_struct));

    p_div_gap_r4: assert property (@(posedge clk) disable iff (rst)
        (issue && in_unit == 2'd3) |-> since_div >= GW'(DIV_II));

    p_int_fwd_r3: assert property (@(posedge clk) disable iff (rst)
        (issue && in_unit == 2'd0 && in_dst_en) |=>
        !(haz_raw && in_srca_en && !in_srcb_en && in_srca == $past(in_dst)));

    p_mul_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (issue && in_unit == 2'd1 && in_dst_en) |=>
        !(in_valid && in_srca_en && in_srca == $past(in_dst) && !haz_raw));

    p_waw_after_mul_r6: assert property (@(posedge clk) disable iff (rst)
        (issue && in_unit == 2'd1 && in_dst_en) |=>
        !(issue && in_dst_en && in_dst == $past(in_dst) &&
          (in_unit == 2'd0 || in_unit == 2'd2)));

endmodule

bind issue_interlock issue_interlock_chk #(.IW(IW), .DIV_II(DIV_II)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_unit    (in_unit),
    .in_dst     (in_dst),
    .in_dst_en  (in_dst_en),
    .in_srca    (in_srca),
    .in_srca_en (in_srca_en),
    .in_srcb_en (in_srcb_en),
    .issue      (issue),
    .stall      (stall),
    .haz_struct (haz_struct),
    .haz_raw    (haz_raw),
    .haz_waw    (haz_waw)
);

// File: tb/issue_interlock_tb_top.sv
`timescale 1ns/100ps
module issue_interlock_tb_top;

    localparam logic [1:0] U_INT = 2'd0;
    localparam logic [1:0] U_MUL = 2'd1;
    localparam logic [1:0] U_ADD = 2'd2;
    localparam logic [1:0] U_DIV = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [1:0] in_unit = 2'd0;
    logic [4:0] in_dst = '0, in_srca = '0, in_srcb = '0;
    logic       in_dst_en = 1'b0, in_srca_en = 1'b0, in_srcb_en = 1'b0;
    logic       issue, stall, haz_struct, haz_raw, haz_waw;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    typedef struct {
        logic  iss;
        logic  stl;
        logic  s;
        logic  r;
        logic  w;
        string req;
    } exp_t;

    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    issue_interlock dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
        .in_dst(in_dst), .in_dst_en(in_dst_en),
        .in_srca(in_srca), .in_srca_en(in_srca_en),
        .in_srcb(in_srcb), .in_srcb_en(in_srcb_en),
        .issue(issue), .stall(stall), .haz_struct(haz_struct),
        .haz_raw(haz_raw), .haz_waw(haz_waw)
    );

    // Driver: present one instruction for one cycle and queue what must be seen
    task automatic drv(input logic v, input logic [1:0] u,
                       input int d, input logic de,
                       input int a, input logic ae,
                       input int b, input logic be,
                       input logic e_iss, input logic e_s,
                       input logic e_r, input logic e_w, input string req);
        exp_t e;
        @(negedge clk);
        in_valid = v; in_unit = u;
        in_dst = 5'(d); in_dst_en = de;
        in_srca = 5'(a); in_srca_en = ae;
        in_srcb = 5'(b); in_srcb_en = be;
        e.iss = e_iss; e.s = e_s; e.r = e_r; e.w = e_w;
        e.stl = e_s | e_r | e_w;
        e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++)
            drv(1'b0, U_INT, 0, 1'b0, 0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
    endtask

    // Monitor: compare mid-cycle, after the driver has settled the inputs
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_checks++;
                if (issue !== e.iss || stall !== e.stl || haz_struct !== e.s ||
                    haz_raw !== e.r || haz_waw !== e.w) begin
                    n_fail++;
                    $display("FAIL %s: got iss=%b stl=%b s=%b r=%b w=%b expected iss=%b stl=%b s=%b r=%b w=%b",
                             e.req, issue, stall, haz_struct, haz_raw, haz_waw,
                             e.iss, e.stl, e.s, e.r, e.w);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: clean state, sources enabled, issues at once; R3: INT back-to-back
        drv(1, U_INT, 1, 1, 2, 1, 3, 1, 1, 0, 0, 0, "R1");
        drv(1, U_INT, 2, 1, 1, 1, 0, 0, 1, 0, 0, 0, "R3");
        idle(30);

        // R3: MUL producer, 6 held cycles; last one also collides on write-back (R5)
        drv(1, U_MUL, 3, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
        for (int i = 1; i <= 6; i++)
            drv(1, U_INT, 4, 1, 3, 1, 0, 0, 0, (i == 6), 1, 0, "R3");
        drv(1, U_INT, 4, 1, 3, 1, 0, 0, 1, 0, 0, 0, "R3");
        idle(30);

        // R3: ADD producer, 3 held cycles
        drv(1, U_ADD, 5, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R3");
        for (int i = 1; i <= 3; i++)
            drv(1, U_INT, 6, 1, 5, 1, 0, 0, 0, (i == 3), 1, 0, "R3");
        drv(1, U_INT, 6, 1, 5, 1, 0, 0, 1, 0, 0, 0, "R3");
        idle(30);

        // R4: second divide blocked 24 cycles, issues on the 25th
        drv(1, U_DIV, 7, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R4");
        for (int i = 1; i <= 24; i++)
            drv(1, U_DIV, 8, 1, 0, 0, 0, 0, 0, 1, 0, 0, "R4");
        drv(1, U_DIV, 8, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R4");
        idle(30);

        // R4: consumer of a divide held 24 cycles
        drv(1, U_DIV, 9, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R4");
        for (int i = 1; i <= 24; i++)
            drv(1, U_INT, 10, 1, 9, 1, 0, 0, 0, (i == 24), 1, 0, "R4");
        drv(1, U_INT, 10, 1, 9, 1, 0, 0, 1, 0, 0, 0, "R4");
        idle(30);

        // R5: ADD three cycles after MUL hits the same write-back cycle
        drv(1, U_MUL, 11, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
        idle(2);
        drv(1, U_ADD, 12, 1, 0, 0, 0, 0, 0, 1, 0, 0, "R5");
        drv(1, U_ADD, 12, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R5");
        idle(30);

        // R6: faster write to a register a MUL is writing is held
        drv(1, U_MUL, 13, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
        drv(1, U_ADD, 13, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
        drv(1, U_ADD, 13, 1, 0, 0, 0, 0, 0, 0, 0, 1, "R6");
        drv(1, U_ADD, 13, 1, 0, 0, 0, 0, 0, 1, 0, 1, "R6");
        drv(1, U_ADD, 13, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
        idle(30);

        // R6: slower write after a faster one to the same register is allowed
        drv(1, U_ADD, 14, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
        drv(1, U_MUL, 14, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R6");
        idle(30);

        // R7: disabled fields ignored; disabled destination leaves nothing pending
        drv(1, U_MUL, 15, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R7");
        drv(1, U_ADD, 16, 0, 15, 0, 15, 0, 1, 0, 0, 0, "R7");
        drv(1, U_INT, 17, 1, 16, 1, 0, 0, 1, 0, 0, 0, "R7");
        idle(30);

        // R8: held ADD reserves neither its destination nor its write-back cycle
        drv(1, U_MUL, 18, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
        drv(1, U_ADD, 19, 1, 18, 1, 0, 0, 0, 0, 1, 0, "R8");
        drv(1, U_INT, 20, 1, 19, 1, 0, 0, 1, 0, 0, 0, "R8");
        idle(1);
        drv(1, U_INT, 21, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
        idle(30);

        // R2: no valid means no flags even with a live dependency
        drv(1, U_MUL, 22, 1, 0, 0, 0, 0, 1, 0, 0, 0, "R2");
        drv(0, U_ADD, 23, 1, 22, 1, 0, 0, 0, 0, 0, 0, "R2");
        drv(1, U_ADD, 23, 1, 22, 1, 0, 0, 0, 0, 1, 0, "R2");
        idle(3);

        wait (sb_q.size() == 0);
        @(negedge clk);
        #3;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule